// File: doc/BRIEF.md
# Condition-Generating Add/Subtract ALU

This block is the integer arithmetic stage of a 32-bit processor pipeline. On each issued operation it adds, subtracts, compares or combines two operands with a bitwise function, and in the same cycle it evaluates a 4-bit condition selector against the outcome. The registered condition tells the pipeline whether to squash the following instruction. Add operations can shift the first operand left by up to three bits first. Carry-chained add and borrow-chained subtract take their carry from the carry-out bit saved by an earlier operation.

Next to the result, the block keeps a per-bit carry vector and a carry-out bit for later decimal-correction or chained steps. Two trap requests can stop an add or subtract from committing: one fires on signed overflow and one fires when the condition holds. Register-file access, decode and exception handling sit outside the block. The block only raises one-cycle request outputs.

Top module: `cond_alu`

## Requirements
- R1: After reset `result`, `carryVec`, `carryMsb`, `ovfFlag`, `nullifyNext`, `resultWe`, `trapOvfReq` and `trapCondReq` are all zero.
- R2: Operation codes are `opSel` 0 = add, 1 = add with carry, 2 = add without carry update. Each computes (`opA` << `shAmt`) + `opB`, and code 1 also adds the stored `carryMsb`. The value is registered in `result` one cycle after `issue`, with `resultWe` high for that cycle.
- R3: Codes 3 = subtract and 4 = subtract with borrow compute `opA` + ~`opB` + c. For code 3, c is 1. For code 4, c is the stored `carryMsb`. No shift is applied.
- R4: Codes 0, 1, 3 and 4 save `carryMsb` = bit 32 of the 33-bit sum, and save `carryVec` = op1' XOR op2' XOR result, where op1' is the shifted first operand and op2' is the addend after any complement. Every other code leaves both unchanged.
- R5: `ovfFlag` is registered on every legal issue. For adds it is bit 31 of (result XOR op1') AND NOT (op1' XOR `opB`). For codes 3, 4 and 5 it is bit 31 of (result XOR `opA`) AND (`opA` XOR `opB`). It is 0 for bitwise codes.
- R6: `condField`[3:1] selects a predicate and `condField`[0] inverts it. The predicates on the result are: 0 never, 1 zero, 2 negative, 3 negative or zero, 4 no carry-out, 5 no carry-out or zero, 6 signed overflow, 7 odd (bit 0 set). The outcome is registered into `nullifyNext`.
- R7: For code 3 and code 5 (compare-and-clear), predicates 1 to 5 compare the operands directly instead: equal, signed less, signed less-or-equal, unsigned less, unsigned less-or-equal. Predicates 0, 6 and 7 keep their general meaning.
- R8: Codes 6 = AND, 7 = AND with complement of `opB`, 8 = OR and 9 = XOR produce the bitwise result. For these codes predicates 4, 5 and 6 read as never, so with the invert bit set they read as always.
- R9: Code 5 writes zero to `result` (with `resultWe` high) and only produces the condition.
- R10: For codes 0 to 4, `trapOvfEn` with signed overflow raises `trapOvfReq`, and `trapCondEn` with a true condition raises `trapCondReq`. A raised trap blocks the update of `result`, `carryVec` and `carryMsb`, keeps `resultWe` low and clears `nullifyNext`.
- R11: Without `issue`, and for unused codes 10 to 15, `result`, `carryVec`, `carryMsb`, `ovfFlag` and `nullifyNext` hold their values, and `resultWe` and both trap requests stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Operation valid strobe |
| opSel | input | 4 | Operation code |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| shAmt | input | 2 | Left pre-shift of `opA` for adds |
| condField | input | 4 | Predicate select [3:1] and invert [0] |
| trapOvfEn | input | 1 | Enable trap on signed overflow |
| trapCondEn | input | 1 | Enable trap on true condition |
| result | output | 32 | Registered destination value |
| resultWe | output | 1 | One-cycle destination write pulse |
| carryVec | output | 32 | Saved per-bit carry vector |
| carryMsb | output | 1 | Saved carry-out bit |
| ovfFlag | output | 1 | Signed overflow of the last legal operation |
| nullifyNext | output | 1 | Registered condition outcome |
| trapOvfReq | output | 1 | One-cycle overflow trap request |
| trapCondReq | output | 1 | One-cycle condition trap request |

## Verification
The assertions check these rules on every cycle:
- A trap pulse never appears together with a write pulse or a set nullify flag.
- An idle cycle leaves the pulses low.
- The result and carry state do not move without a commit strobe.
- Compare-and-clear leaves zero behind.
- The never predicate never nullifies.
- A plain subtract's sum equals the operand difference.

The directed scenarios cover what a per-cycle property cannot see:
- the exact arithmetic values and per-bit carry vectors;
- carry chaining between consecutive operations;
- the difference between a direct signed compare and a flag-based test when the subtraction overflows;
- the predicates that bitwise operations reduce;
- result suppression under each trap kind.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD    = 4'd0,
    OP_ADDC   = 4'd1,
    OP_ADDL   = 4'd2,
    OP_SUB    = 4'd3,
    OP_SUBB   = 4'd4,
    OP_CMPCLR = 4'd5,
    OP_AND    = 4'd6,
    OP_ANDCM  = 4'd7,
    OP_OR     = 4'd8,
    OP_XOR    = 4'd9
  } aluOpE;

  typedef enum logic [1:0] {
    LF_AND   = 2'd0,
    LF_ANDCM = 2'd1,
    LF_OR    = 2'd2,
    LF_XOR   = 2'd3
  } logicFnE;

  typedef enum logic [1:0] {
    CIN_ZERO   = 2'd0,
    CIN_ONE    = 2'd1,
    CIN_STORED = 2'd2
  } cinSelE;

  // operand and function selects, driven by decode only
  typedef struct packed {
    logic    shiftOp1;
    logic    invertB;
    cinSelE  cinSel;
    logic    isLogic;
    logicFnE logicFn;
    logic    directCmp;
    logic    clearDest;
    logic    subOvf;
  } dpSelT;

  // commit strobes, driven after trap evaluation
  typedef struct packed {
    logic wrResult;
    logic wrCarry;
    logic wrFlags;
  } dpCommitT;

endpackage

// File: rtl/cond_alu_cond.sv
module cond_alu_cond #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  input  logic [WIDTH-1:0] cmpA,
  input  logic [WIDTH-1:0] cmpB,
  input  logic             carryOut,
  input  logic             ovf,
  input  logic             isLogic,
  input  logic             directCmp,
  input  logic [3:0]       condField,
  output logic             condHit
);

  localparam int MSB = WIDTH - 1;

  logic [2:0] predCode;
  logic       resZero, resNeg;
  logic       sLess, sLessEq, uLess, uLessEq, opEq;
  logic       predVal;

  assign predCode = condField[3:1];
  assign resZero  = (res == '0);
  assign resNeg   = res[MSB];
  assign opEq     = (cmpA == cmpB);
  assign sLess    = ($signed(cmpA) < $signed(cmpB));
  assign sLessEq  = sLess | opEq;
  assign uLess    = (cmpA < cmpB);
  assign uLessEq  = uLess | opEq;

  always_comb begin
    predVal = 1'b0;
    case (predCode)
      3'd0: predVal = 1'b0;
      3'd1: predVal = directCmp ? opEq    : resZero;
      3'd2: predVal = directCmp ? sLess   : resNeg;
      3'd3: predVal = directCmp ? sLessEq : (resNeg | resZero);
      3'd4: predVal = isLogic ? 1'b0 : (directCmp ? uLess   : ~carryOut);
      3'd5: predVal = isLogic ? 1'b0 : (directCmp ? uLessEq : (~carryOut | resZero));
      3'd6: predVal = isLogic ? 1'b0 : ovf;
      3'd7: predVal = res[0];
      default: predVal = 1'b0;
    endcase
  end

  assign condHit = predVal ^ condField[0];

endmodule

// File: rtl/cond_alu_dp.sv
module cond_alu_dp
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  logic [3:0]       condField,
  input  dpSelT            sel,
  input  dpCommitT         com,
  output logic             condHit,
  output logic             ovfNow,
  output logic [WIDTH-1:0] resultQ,
  output logic [WIDTH-1:0] carryVecQ,
  output logic             carryMsbQ,
  output logic             ovfQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] opAEff, opBEff, logicRes, rawRes, writeVal;
  logic [WIDTH-1:0] ovfAddVec, ovfSubVec;
  logic [WIDTH:0]   sumWide;
  logic             cin, carryOut;

  assign opAEff = sel.shiftOp1 ? (opA << shAmt) : opA;
  assign opBEff = sel.invertB ? ~opB : opB;

  always_comb begin
    case (sel.cinSel)
      CIN_ONE:    cin = 1'b1;
      CIN_STORED: cin = carryMsbQ;
      default:    cin = 1'b0;
    endcase
  end

  assign sumWide  = {1'b0, opAEff} + {1'b0, opBEff} + {{WIDTH{1'b0}}, cin};
  assign carryOut = sumWide[WIDTH];

  always_comb begin
    case (sel.logicFn)
      LF_AND:   logicRes = opA & opB;
      LF_ANDCM: logicRes = opA & ~opB;
      LF_OR:    logicRes = opA | opB;
      default:  logicRes = opA ^ opB;
    endcase
  end

  assign rawRes    = sel.isLogic ? logicRes : sumWide[MSB:0];
  assign ovfAddVec = (rawRes ^ opAEff) & ~(opAEff ^ opB);
  assign ovfSubVec = (rawRes ^ opAEff) & (opAEff ^ opB);
  assign ovfNow    = sel.isLogic ? 1'b0 : (sel.subOvf ? ovfSubVec[MSB] : ovfAddVec[MSB]);
  assign writeVal  = sel.clearDest ? '0 : rawRes;

  cond_alu_cond #(.WIDTH(WIDTH)) cond_i (
    .res       (rawRes),
    .cmpA      (opAEff),
    .cmpB      (opB),
    .carryOut  (carryOut),
    .ovf       (ovfNow),
    .isLogic   (sel.isLogic),
    .directCmp (sel.directCmp),
    .condField (condField),
    .condHit   (condHit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultQ   <= '0;
      carryVecQ <= '0;
      carryMsbQ <= 1'b0;
      ovfQ      <= 1'b0;
    end else begin
      if (com.wrResult) resultQ <= writeVal;
      if (com.wrCarry) begin
        carryVecQ <= opAEff ^ opBEff ^ rawRes;
        carryMsbQ <= carryOut;
      end
      if (com.wrFlags) ovfQ <= ovfNow;
    end
  end

  // R3
  always_comb begin
    if (rst_n && !sel.isLogic && sel.invertB && sel.cinSel == CIN_ONE && !sel.shiftOp1) begin
      sub_value_chk: assert (sumWide[MSB:0] == opA - opB);
    end
  end

  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !com.wrResult |=> $stable(resultQ));

  // R4
  carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !com.wrCarry |=> ($stable(carryVecQ) && $stable(carryMsbQ)));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (com.wrResult && sel.clearDest) |=> (resultQ == '0));

endmodule

// File: rtl/cond_alu_ctrl.sv
module cond_alu_ctrl
  import cond_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       issue,
  input  logic [3:0] opSel,
  input  logic [3:0] condField,
  input  logic       trapOvfEn,
  input  logic       trapCondEn,
  input  logic       condHit,
  input  logic       ovfNow,
  output dpSelT      sel,
  output dpCommitT   com,
  output logic       nullifyQ,
  output logic       resultWeQ,
  output logic       trapOvfQ,
  output logic       trapCondQ
);

  logic legal, arith, saveCarry;
  logic trapOvf, trapCond, anyTrap, accept;

  always_comb begin
    sel       = '{shiftOp1: 1'b0, invertB: 1'b0, cinSel: CIN_ZERO, isLogic: 1'b0,
                  logicFn: LF_AND, directCmp: 1'b0, clearDest: 1'b0, subOvf: 1'b0};
    legal     = 1'b1;
    arith     = 1'b0;
    saveCarry = 1'b0;
    case (opSel)
      OP_ADD:  begin sel.shiftOp1 = 1'b1; arith = 1'b1; saveCarry = 1'b1; end
      OP_ADDC: begin sel.shiftOp1 = 1'b1; sel.cinSel = CIN_STORED; arith = 1'b1; saveCarry = 1'b1; end
      OP_ADDL: begin sel.shiftOp1 = 1'b1; arith = 1'b1; end
      OP_SUB: begin
        sel.invertB = 1'b1; sel.cinSel = CIN_ONE; sel.directCmp = 1'b1; sel.subOvf = 1'b1;
        arith = 1'b1; saveCarry = 1'b1;
      end
      OP_SUBB: begin
        sel.invertB = 1'b1; sel.cinSel = CIN_STORED; sel.subOvf = 1'b1;
        arith = 1'b1; saveCarry = 1'b1;
      end
      OP_CMPCLR: begin
        sel.invertB = 1'b1; sel.cinSel = CIN_ONE; sel.directCmp = 1'b1; sel.subOvf = 1'b1;
        sel.clearDest = 1'b1;
      end
      OP_AND:   begin sel.isLogic = 1'b1; sel.logicFn = LF_AND;   end
      OP_ANDCM: begin sel.isLogic = 1'b1; sel.logicFn = LF_ANDCM; end
      OP_OR:    begin sel.isLogic = 1'b1; sel.logicFn = LF_OR;    end
      OP_XOR:   begin sel.isLogic = 1'b1; sel.logicFn = LF_XOR;   end
      default:  legal = 1'b0;
    endcase
  end

  assign accept   = issue & legal;
  assign trapOvf  = accept & arith & trapOvfEn & ovfNow;
  assign trapCond = accept & arith & trapCondEn & condHit;
  assign anyTrap  = trapOvf | trapCond;

  assign com.wrResult = accept & ~anyTrap;
  assign com.wrCarry  = accept & ~anyTrap & saveCarry;
  assign com.wrFlags  = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nullifyQ  <= 1'b0;
      resultWeQ <= 1'b0;
      trapOvfQ  <= 1'b0;
      trapCondQ <= 1'b0;
    end else begin
      if (accept) nullifyQ <= condHit & ~anyTrap;
      resultWeQ <= com.wrResult;
      trapOvfQ  <= trapOvf;
      trapCondQ <= trapCond;
    end
  end

  // R10
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trapOvfQ || trapCondQ) |-> (!resultWeQ && !nullifyQ));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> (!resultWeQ && !trapOvfQ && !trapCondQ));

  // R6
  never_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && condField == 4'd0) |=> !nullifyQ);

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SHW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [3:0]       opSel,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SHW-1:0]   shAmt,
  input  logic [3:0]       condField,
  input  logic             trapOvfEn,
  input  logic             trapCondEn,
  output logic [WIDTH-1:0] result,
  output logic             resultWe,
  output logic [WIDTH-1:0] carryVec,
  output logic             carryMsb,
  output logic             ovfFlag,
  output logic             nullifyNext,
  output logic             trapOvfReq,
  output logic             trapCondReq
);

  dpSelT    sel;
  dpCommitT com;
  logic     condHit, ovfNow;

  cond_alu_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .opSel      (opSel),
    .condField  (condField),
    .trapOvfEn  (trapOvfEn),
    .trapCondEn (trapCondEn),
    .condHit    (condHit),
    .ovfNow     (ovfNow),
    .sel        (sel),
    .com        (com),
    .nullifyQ   (nullifyNext),
    .resultWeQ  (resultWe),
    .trapOvfQ   (trapOvfReq),
    .trapCondQ  (trapCondReq)
  );

  cond_alu_dp #(.WIDTH(WIDTH), .SHW(SHW)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .opA       (opA),
    .opB       (opB),
    .shAmt     (shAmt),
    .condField (condField),
    .sel       (sel),
    .com       (com),
    .condHit   (condHit),
    .ovfNow    (ovfNow),
    .resultQ   (result),
    .carryVecQ (carryVec),
    .carryMsbQ (carryMsb),
    .ovfQ      (ovfFlag)
  );

endmodule

// File: tb/cond_alu_tb_top.sv
module cond_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [3:0]  opSel = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  shAmt = '0;
  logic [3:0]  condField = '0;
  logic        trapOvfEn = 1'b0, trapCondEn = 1'b0;
  logic [31:0] result, carryVec;
  logic        resultWe, carryMsb, ovfFlag, nullifyNext, trapOvfReq, trapCondReq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cond_alu dut_i (
    .clk(clk), .rst_n(rst_n), .issue(issue), .opSel(opSel), .opA(opA), .opB(opB),
    .shAmt(shAmt), .condField(condField), .trapOvfEn(trapOvfEn), .trapCondEn(trapCondEn),
    .result(result), .resultWe(resultWe), .carryVec(carryVec), .carryMsb(carryMsb),
    .ovfFlag(ovfFlag), .nullifyNext(nullifyNext), .trapOvfReq(trapOvfReq),
    .trapCondReq(trapCondReq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive one operation at a falling edge; return at the next falling edge
  task automatic doOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [1:0] sh, input logic [3:0] cf,
                      input logic tOv = 1'b0, input logic tCd = 1'b0);
    @(negedge clk);
    opSel = op; opA = a; opB = b; shAmt = sh; condField = cf;
    trapOvfEn = tOv; trapCondEn = tCd; issue = 1'b1;
    @(negedge clk);
    issue = 1'b0; trapOvfEn = 1'b0; trapCondEn = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 result", result, 0);
    chk("R1 carryVec", carryVec, 0);
    chk("R1 flags", {resultWe, carryMsb, ovfFlag, nullifyNext, trapOvfReq, trapCondReq}, 0);
  endtask

  task automatic t_add;
    doOp(4'd0, 32'd5, 32'd7, 2'd0, 4'd0);
    chk("R2 add result", result, 32'd12);
    chk("R2 add we", resultWe, 1);
    chk("R4 add carryVec", carryVec, 32'hE);
    chk("R6 never", nullifyNext, 0);
    doOp(4'd0, 32'd3, 32'd1, 2'd2, 4'd3);
    chk("R2 shifted add", result, 32'd13);
    chk("R6 nonzero", nullifyNext, 1);
    doOp(4'd0, 32'hFFFF_FFFF, 32'd1, 2'd0, 4'd2);
    chk("R2 wrap result", result, 0);
    chk("R4 carryMsb set", carryMsb, 1);
    chk("R4 carryVec wrap", carryVec, 32'hFFFF_FFFE);
    chk("R6 zero", nullifyNext, 1);
  endtask

  task automatic t_addc;
    doOp(4'd1, 32'd0, 32'd0, 2'd0, 4'd0);
    chk("R2 addc uses carry", result, 32'd1);
    chk("R4 addc carry clear", carryMsb, 0);
  endtask

  task automatic t_addl;
    doOp(4'd0, 32'hFFFF_FFFF, 32'd1, 2'd0, 4'd0);
    doOp(4'd2, 32'hFFFF_FFFF, 32'd2, 2'd0, 4'd8);
    chk("R2 addl result", result, 32'd1);
    chk("R4 addl keeps carryVec", carryVec, 32'hFFFF_FFFE);
    chk("R4 addl keeps carryMsb", carryMsb, 1);
    chk("R6 no-carry false", nullifyNext, 0);
  endtask

  task automatic t_ovf;
    doOp(4'd0, 32'h7FFF_FFFF, 32'd1, 2'd0, 4'd12);
    chk("R5 add ovf", ovfFlag, 1);
    chk("R6 ovf pred", nullifyNext, 1);
    doOp(4'd0, 32'd1, 32'd1, 2'd0, 4'd0);
    chk("R5 no ovf", ovfFlag, 0);
    doOp(4'd0, 32'h7FFF_FFFF, 32'd1, 2'd0, 4'd0, 1'b1, 1'b0);
    chk("R10 ovf trap req", trapOvfReq, 1);
    chk("R10 ovf trap no we", resultWe, 0);
    chk("R10 ovf trap result held", result, 32'd2);
    chk("R10 ovf trap carry held", carryVec, 32'd2);
    chk("R10 ovf trap nullify", nullifyNext, 0);
  endtask

  task automatic t_sub;
    doOp(4'd3, 32'h8000_0000, 32'd1, 2'd0, 4'd4);
    chk("R3 sub result", result, 32'h7FFF_FFFF);
    chk("R5 sub ovf", ovfFlag, 1);
    chk("R7 direct signed less", nullifyNext, 1);
    chk("R4 sub carry", carryMsb, 1);
    doOp(4'd3, 32'd1, 32'd2, 2'd0, 4'd8);
    chk("R7 unsigned less", nullifyNext, 1);
    doOp(4'd3, 32'd2, 32'd2, 2'd0, 4'd10);
    chk("R7 unsigned le", nullifyNext, 1);
    doOp(4'd3, 32'd2, 32'd2, 2'd0, 4'd8);
    chk("R7 unsigned less equal ops", nullifyNext, 0);
    doOp(4'd3, 32'd5, 32'd3, 2'd0, 4'd0);
    chk("R3 sub 5-3", result, 32'd2);
    chk("R4 sub carryVec", carryVec, 32'hFFFF_FFFB);
  endtask

  task automatic t_subb;
    doOp(4'd3, 32'd3, 32'd5, 2'd0, 4'd0);
    chk("R4 borrow state", carryMsb, 0);
    doOp(4'd4, 32'd5, 32'd3, 2'd0, 4'd2);
    chk("R3 subb borrow", result, 32'd1);
    chk("R4 subb carry", carryMsb, 1);
    chk("R4 subb carryVec", carryVec, 32'hFFFF_FFF8);
    chk("R6 subb nonzero", nullifyNext, 0);
    doOp(4'd4, 32'd5, 32'd3, 2'd0, 4'd0);
    chk("R3 subb no borrow", result, 32'd2);
  endtask

  task automatic t_cmpclr;
    doOp(4'd5, 32'd4, 32'd4, 2'd0, 4'd2);
    chk("R9 cmpclr zero", result, 0);
    chk("R9 cmpclr we", resultWe, 1);
    chk("R7 cmpclr equal", nullifyNext, 1);
    chk("R4 cmpclr keeps carryVec", carryVec, 32'hFFFF_FFFB);
    doOp(4'd5, 32'h8000_0000, 32'd1, 2'd0, 4'd4);
    chk("R7 cmpclr signed less", nullifyNext, 1);
  endtask

  task automatic t_logic;
    doOp(4'd6, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 4'd8);
    chk("R8 and", result, 32'hF000_F000);
    chk("R8 code4 never", nullifyNext, 0);
    doOp(4'd6, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 4'd9);
    chk("R8 code4 inverted", nullifyNext, 1);
    doOp(4'd7, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 4'd12);
    chk("R8 andcm", result, 32'h00F0_00F0);
    chk("R8 code6 never", nullifyNext, 0);
    doOp(4'd8, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 4'd13);
    chk("R8 or", result, 32'hFFF0_FFF0);
    chk("R8 code6 inverted", nullifyNext, 1);
    doOp(4'd9, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 4'd14);
    chk("R8 xor", result, 32'h0FF0_0FF0);
    chk("R6 even", nullifyNext, 0);
    doOp(4'd9, 32'hF0F0_F0F0, 32'hFF00_FF00, 2'd0, 4'd15);
    chk("R6 odd inverted", nullifyNext, 1);
    chk("R4 logic keeps carryVec", carryVec, 32'hFFFF_FFFB);
    chk("R5 logic ovf", ovfFlag, 0);
  endtask

  task automatic t_trapc;
    doOp(4'd0, 32'd1, 32'd1, 2'd0, 4'd0);
    doOp(4'd3, 32'd2, 32'd2, 2'd0, 4'd2, 1'b0, 1'b1);
    chk("R10 cond trap req", trapCondReq, 1);
    chk("R10 cond trap no we", resultWe, 0);
    chk("R10 cond trap result held", result, 32'd2);
    chk("R10 cond trap nullify", nullifyNext, 0);
    doOp(4'd0, 32'd1, 32'd2, 2'd0, 4'd2, 1'b0, 1'b1);
    chk("R10 cond false no trap", trapCondReq, 0);
    chk("R10 cond false writes", result, 32'd3);
  endtask

  task automatic t_never_idle;
    doOp(4'd0, 32'd0, 32'd0, 2'd0, 4'd1);
    chk("R6 always", nullifyNext, 1);
    repeat (3) @(negedge clk);
    chk("R11 idle result", result, 0);
    chk("R11 idle nullify", nullifyNext, 1);
    chk("R11 idle we", resultWe, 0);
    doOp(4'd12, 32'd9, 32'd9, 2'd0, 4'd0);
    chk("R11 unused code result", result, 0);
    chk("R11 unused code we", resultWe, 0);
    chk("R11 unused code nullify", nullifyNext, 1);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_addc();
    t_addl();
    t_ovf();
    t_sub();
    t_subb();
    t_cmpclr();
    t_logic();
    t_trapc();
    t_never_idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule